// File: doc/BRIEF.md
# Four-Tributary Bit-Interleaved Frame Multiplexer

This block merges four serial lower-rate tributaries into one serial aggregate stream organised as 848-bit frames. It runs on the aggregate bit clock and emits one bit per cycle. Each frame is built from four consecutive 212-bit sets. Every set holds a short overhead segment followed by payload, and the payload takes one bit from each tributary in rotation. Overhead consists of a ten-bit alignment word, an alarm bit, a spare bit, three justification-control bits per tributary spread over the later sets, and one justification-opportunity bit per tributary. The opportunity bit lets a slower tributary give up one payload bit in a frame.

Upstream rate-adaptation buffers present one data bit and an "available" flag per tributary. They advance when the block raises that tributary's read strobe. A separate decision stage raises a per-tributary justification request. The block captures the request once per frame, at the frame boundary, and applies it to the whole next frame. A sequencer with five named segment states walks the frame: `ST_ALIGN` (alignment word), `ST_SERVICE` (alarm and spare bits), `ST_PAYLOAD` (interleaved tributary bits), `ST_JCTRL` (control bits) and `ST_JOPP` (opportunity bits). The transitions are as follows:
- `ST_ALIGN`→`ST_SERVICE` after 10 bits.
- `ST_SERVICE`→`ST_PAYLOAD` after 2 bits.
- `ST_PAYLOAD`→`ST_JCTRL` at the end of sets 1 to 3.
- `ST_PAYLOAD`→`ST_ALIGN` at the end of set 4.
- `ST_JCTRL`→`ST_PAYLOAD` in sets 2 and 3.
- `ST_JCTRL`→`ST_JOPP` in set 4.
- `ST_JOPP`→`ST_PAYLOAD`.

Top module: `quad_frame_mux`

## Requirements
- R1: While `rst_i` is high at a rising edge, `ser_o`, `sof_o` and `rd_stb_o` are 0 in the following cycle. After release, the frame restarts at position 0.
- R2: `sof_o` is high for exactly one cycle in every 848. That cycle is the one in which `ser_o` carries frame position 0.
- R3: Frame positions 0..9 carry 1111010000, leftmost bit first. Position 10 carries the alarm bit (default 0) and position 11 carries the spare bit (default 1).
- R4: Payload occupies positions 12..211, 216..423, 428..635 and 644..847. In each of these ranges, the tributary index is (position − range start) mod 4, starting with tributary 0.
- R5: In a payload slot of tributary k whose available flag is high, `ser_o` in the next cycle equals the value `trib_i[k]` held in the strobe cycle.
- R6: Positions 212+k, 424+k and 636+k carry 1 if tributary k is justified in the current frame, and 0 otherwise.
- R7: Position 640+k is tributary k's opportunity bit. If k is justified, it carries 0 and k gets no strobe. Otherwise it is treated as a payload slot of k.
- R8: `rd_stb_o[k]` is high only in a data slot of tributary k while `avail_i[k]` is high, so at most one strobe is high per cycle. If `avail_i[k]` is low in k's data slot, that bit carries fill value 1 and no strobe is given.
- R9: `jreq_i` is captured at the rising edge that ends position 847 and governs the next frame. The first frame after reset is unjustified, whatever `jreq_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Aggregate bit clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trib_i | input | 4 | Current head bit of each tributary buffer |
| avail_i | input | 4 | Per-tributary flag: a buffered bit is present |
| jreq_i | input | 4 | Per-tributary justification request for the next frame |
| ser_o | output | 1 | Serial aggregate frame bit |
| sof_o | output | 1 | High with the first alignment-word bit |
| rd_stb_o | output | 4 | Per-tributary read strobe; the buffer advances on the edge that ends it |

## Verification
The read strobes depend only on the registered frame position, so they are due in the same cycle as that position. `ser_o` and `sof_o` pass through one more register and are due one rising edge later. A justification request shows up only in the frame after the wrap edge at which it was captured. The bench keeps its own position counter. At each falling edge it compares the strobes for the current position, then waits one falling edge and compares the serial bit and start-of-frame marker it predicted for that position. It latches its expected justification set at the same wrap edge as the design does.

// File: rtl/qfm_pkg.sv
package qfm_pkg;

    // Segment states of the frame sequencer.
    typedef enum logic [2:0] {
        ST_ALIGN,
        ST_SERVICE,
        ST_PAYLOAD,
        ST_JCTRL,
        ST_JOPP
    } seg_e;

endpackage

// File: rtl/qfm_seq.sv
module qfm_seq
    import qfm_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    parameter int SET_LEN  = 212,
    parameter int NUM_SETS = 4,
    parameter int FAW_LEN  = 10,
    parameter int SVC_LEN  = 2,
    localparam int CNT_W   = $clog2(SET_LEN),
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output seg_e             seg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frame_last_o
);

    // Payload lengths of first, middle and last set.
    localparam int PAY_FIRST = SET_LEN - FAW_LEN - SVC_LEN;
    localparam int PAY_MID   = SET_LEN - NUM_TRIB;
    localparam int PAY_LAST  = SET_LEN - 2 * NUM_TRIB;
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    seg_e             seg_q, seg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, seg_len;
    logic [SET_W-1:0] set_q, set_d;
    logic             seg_end;

    // Length of the segment currently being sent.
    always_comb begin : len_sel
        unique case (seg_q)
            ST_ALIGN:   seg_len = CNT_W'(FAW_LEN);
            ST_SERVICE: seg_len = CNT_W'(SVC_LEN);
            ST_JCTRL:   seg_len = CNT_W'(NUM_TRIB);
            ST_JOPP:    seg_len = CNT_W'(NUM_TRIB);
            ST_PAYLOAD: begin
                if (set_q == '0)
                    seg_len = CNT_W'(PAY_FIRST);
                else if (set_q == LAST_SET)
                    seg_len = CNT_W'(PAY_LAST);
                else
                    seg_len = CNT_W'(PAY_MID);
            end
            default:    seg_len = CNT_W'(FAW_LEN);
        endcase
    end

    assign seg_end = (cnt_q == seg_len - 1'b1);

    // Next-state logic: walk the segments of each set.
    always_comb begin : next_state
        seg_d = seg_q;
        set_d = set_q;
        cnt_d = cnt_q + 1'b1;
        if (seg_end) begin
            cnt_d = '0;
            unique case (seg_q)
                ST_ALIGN:   seg_d = ST_SERVICE;
                ST_SERVICE: seg_d = ST_PAYLOAD;
                ST_PAYLOAD: begin
                    if (set_q == LAST_SET) begin
                        seg_d = ST_ALIGN;
                        set_d = '0;
                    end else begin
                        seg_d = ST_JCTRL;
                        set_d = set_q + 1'b1;
                    end
                end
                ST_JCTRL:   seg_d = (set_q == LAST_SET) ? ST_JOPP : ST_PAYLOAD;
                ST_JOPP:    seg_d = ST_PAYLOAD;
                default:    seg_d = ST_ALIGN;
            endcase
        end
    end

    // State register (R1: reset returns to frame position 0).
    always_ff @(posedge clk_i) begin : state_reg
        if (rst_i) begin
            seg_q <= ST_ALIGN;
            cnt_q <= '0;
            set_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
            set_q <= set_d;
        end
    end

    assign seg_o        = seg_q;
    assign cnt_o        = cnt_q;
    assign frame_last_o = (seg_q == ST_PAYLOAD) && (set_q == LAST_SET) && seg_end;

endmodule

// File: rtl/qfm_slot_map.sv
module qfm_slot_map
    import qfm_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    localparam int LANE_W  = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1
) (
    input  seg_e              seg_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [NUM_TRIB-1:0] just_i,
    input  logic [NUM_TRIB-1:0] avail_i,
    output logic              data_slot_o,
    output logic [NUM_TRIB-1:0] rd_stb_o
);

    // A data slot is a payload bit or an unjustified opportunity bit (R7).
    always_comb begin : slot_kind
        unique case (seg_i)
            ST_PAYLOAD: data_slot_o = 1'b1;
            ST_JOPP:    data_slot_o = ~just_i[lane_i];
            default:    data_slot_o = 1'b0;
        endcase
    end

    // One strobe per lane, gated by availability (R8).
    for (genvar k = 0; k < NUM_TRIB; k++) begin : g_lane
        assign rd_stb_o[k] = data_slot_o && (lane_i == LANE_W'(k)) && avail_i[k];
    end

endmodule

// File: rtl/qfm_bit_gen.sv
module qfm_bit_gen
    import qfm_pkg::*;
#(
    parameter int NUM_TRIB  = 4,
    parameter int FAW_LEN   = 10,
    parameter logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000,
    parameter logic ALARM_BIT = 1'b0,
    parameter logic SPARE_BIT = 1'b1,
    parameter logic FILL_BIT  = 1'b1,
    localparam int LANE_W    = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
    localparam int FAW_IDX_W = $clog2(FAW_LEN)
) (
    input  seg_e                 seg_i,
    input  logic [FAW_IDX_W-1:0] cnt_i,
    input  logic [LANE_W-1:0]    lane_i,
    input  logic                 data_slot_i,
    input  logic [NUM_TRIB-1:0]  just_i,
    input  logic [NUM_TRIB-1:0]  avail_i,
    input  logic [NUM_TRIB-1:0]  trib_i,
    output logic                 bit_o
);

    logic [FAW_IDX_W-1:0] faw_idx;
    logic                 payload_bit;

    // Alignment word goes out leftmost bit first (R3).
    assign faw_idx     = FAW_IDX_W'(FAW_LEN - 1) - cnt_i;
    assign payload_bit = avail_i[lane_i] ? trib_i[lane_i] : FILL_BIT;

    always_comb begin : bit_sel
        unique case (seg_i)
            ST_ALIGN:   bit_o = FAW_WORD[faw_idx];
            ST_SERVICE: bit_o = (cnt_i[0] == 1'b0) ? ALARM_BIT : SPARE_BIT;
            ST_JCTRL:   bit_o = just_i[lane_i];                   // R6
            ST_JOPP:    bit_o = data_slot_i ? payload_bit : 1'b0; // R7
            ST_PAYLOAD: bit_o = payload_bit;                      // R5
            default:    bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/quad_frame_mux.sv
module quad_frame_mux
    import qfm_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    parameter int SET_LEN  = 212,
    parameter int NUM_SETS = 4,
    parameter int FAW_LEN  = 10,
    parameter logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000,
    parameter logic ALARM_BIT = 1'b0,
    parameter logic SPARE_BIT = 1'b1,
    parameter logic FILL_BIT  = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_TRIB-1:0] trib_i,
    input  logic [NUM_TRIB-1:0] avail_i,
    input  logic [NUM_TRIB-1:0] jreq_i,
    output logic                ser_o,
    output logic                sof_o,
    output logic [NUM_TRIB-1:0] rd_stb_o
);

    localparam int SVC_LEN   = 2;
    localparam int CNT_W     = $clog2(SET_LEN);
    localparam int LANE_W    = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1;
    localparam int FAW_IDX_W = $clog2(FAW_LEN);

    seg_e                seg;
    logic [CNT_W-1:0]    cnt;
    logic                frame_last;
    logic [LANE_W-1:0]   lane;
    logic                data_slot;
    logic                nxt_bit;
    logic [NUM_TRIB-1:0] just_q;

    qfm_seq #(
        .NUM_TRIB (NUM_TRIB),
        .SET_LEN  (SET_LEN),
        .NUM_SETS (NUM_SETS),
        .FAW_LEN  (FAW_LEN),
        .SVC_LEN  (SVC_LEN)
    ) seq_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .seg_o        (seg),
        .cnt_o        (cnt),
        .frame_last_o (frame_last)
    );

    // Segments with per-lane content have lengths that are multiples of NUM_TRIB.
    assign lane = cnt[LANE_W-1:0];

    qfm_slot_map #(
        .NUM_TRIB (NUM_TRIB)
    ) map_i (
        .seg_i       (seg),
        .lane_i      (lane),
        .just_i      (just_q),
        .avail_i     (avail_i),
        .data_slot_o (data_slot),
        .rd_stb_o    (rd_stb_o)
    );

    qfm_bit_gen #(
        .NUM_TRIB  (NUM_TRIB),
        .FAW_LEN   (FAW_LEN),
        .FAW_WORD  (FAW_WORD),
        .ALARM_BIT (ALARM_BIT),
        .SPARE_BIT (SPARE_BIT),
        .FILL_BIT  (FILL_BIT)
    ) gen_i (
        .seg_i       (seg),
        .cnt_i       (cnt[FAW_IDX_W-1:0]),
        .lane_i      (lane),
        .data_slot_i (data_slot),
        .just_i      (just_q),
        .avail_i     (avail_i),
        .trib_i      (trib_i),
        .bit_o       (nxt_bit)
    );

    // Justification set is captured at the frame wrap only (R9).
    always_ff @(posedge clk_i) begin : just_reg
        if (rst_i)
            just_q <= '0;
        else if (frame_last)
            just_q <= jreq_i;
    end

    // Output register: one edge after the position is selected.
    always_ff @(posedge clk_i) begin : out_reg
        if (rst_i) begin
            ser_o <= 1'b0;
            sof_o <= 1'b0;
        end else begin
            ser_o <= nxt_bit;
            sof_o <= (seg == ST_ALIGN) && (cnt == '0);
        end
    end

endmodule

// File: rtl/qfm_checker.sv
module qfm_checker #(
    parameter int NUM_TRIB  = 4,
    parameter int FRAME_LEN = 848,
    parameter logic FAW_FIRST = 1'b1,
    localparam int GAP_W    = $clog2(FRAME_LEN) + 1
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                ser_o,
    input logic                sof_o,
    input logic [NUM_TRIB-1:0] rd_stb_o,
    input logic [NUM_TRIB-1:0] avail_i
);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the last start-of-frame marker.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sof_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (!sof_o && !ser_o && rd_stb_o == '0));

    assert_sof_period_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_q |-> (sof_o == (gap_q == GAP_W'(FRAME_LEN - 1))));

    assert_sof_faw_bit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_o |-> (ser_o == FAW_FIRST));

    assert_no_stb_in_align_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_o |-> (rd_stb_o == '0));

    assert_stb_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(rd_stb_o));

    assert_stb_needs_avail_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_o & ~avail_i) == '0);

endmodule

bind quad_frame_mux qfm_checker chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ser_o    (ser_o),
    .sof_o    (sof_o),
    .rd_stb_o (rd_stb_o),
    .avail_i  (avail_i)
);

// File: tb/quad_frame_mux_tb_top.sv
`timescale 1ns/1ps
module quad_frame_mux_tb_top;

    localparam int SL = 212;
    localparam int FL = 848;
    localparam logic [9:0] ALIGN_WORD = 10'b1111010000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] trib, avail, jreq;
    logic       ser, sof;
    logic [3:0] stb;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    int   ep;
    logic [3:0] ejust;
    int   rdcnt [4];

    always #2 clk = ~clk;

    quad_frame_mux dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .trib_i   (trib),
        .avail_i  (avail),
        .jreq_i   (jreq),
        .ser_o    (ser),
        .sof_o    (sof),
        .rd_stb_o (stb)
    );

    function automatic logic pat(int k, int n);
        return ((n * (k + 3) + (n >> 2) + k) % 5) < 2;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp, int pos);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, pos, act, exp);
        end
    endtask

    task automatic drive_data();
        for (int k = 0; k < 4; k++) trib[k] = pat(k, rdcnt[k]);
    endtask

    // Called at a falling edge with the design at frame position ep.
    task automatic step();
        int s, o, kind, lane, p;
        logic eb, esof;
        logic [3:0] es;
        string tag;
        p = ep; s = ep / SL; o = ep % SL; es = '0; lane = 0; kind = 3;
        if (s == 0) begin
            if (o < 10) kind = 0;
            else if (o == 10) kind = 1;
            else if (o == 11) kind = 2;
            else lane = (o - 12) % 4;
        end else if (o < 4) begin
            kind = 4; lane = o;
        end else if (s == 3 && o < 8) begin
            kind = 5; lane = o - 4;
        end else begin
            lane = (s == 3) ? (o - 8) % 4 : (o - 4) % 4;
        end
        case (kind)
            0: begin eb = ALIGN_WORD[9 - o]; tag = "R3 alignment"; end
            1: begin eb = 1'b0; tag = "R3 alarm"; end
            2: begin eb = 1'b1; tag = "R3 spare"; end
            4: begin eb = ejust[lane]; tag = "R6 R9 control"; end
            default: begin
                if (kind == 5 && ejust[lane]) begin
                    eb = 1'b0; tag = "R7 dummy";
                end else if (!avail[lane]) begin
                    eb = 1'b1; tag = "R8 fill";
                end else begin
                    eb = trib[lane]; es[lane] = 1'b1;
                    tag = (kind == 5) ? "R7 opportunity" : "R4 R5 payload";
                end
            end
        endcase
        esof = (p == 0);
        check(stb === es, "R8 read strobe", int'(stb), int'(es), p);
        for (int k = 0; k < 4; k++) if (es[k]) rdcnt[k]++;
        if (ep == FL - 1) begin
            ejust = jreq;
            ep = 0;
        end else begin
            ep++;
        end
        @(negedge clk);
        check(ser === eb, tag, int'(ser), int'(eb), p);
        check(sof === esof, "R2 start of frame", int'(sof), int'(esof), p);
        drive_data();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        rst = 1'b1; avail = 4'hF; jreq = 4'hF;
        ep = 0; ejust = '0;
        for (int k = 0; k < 4; k++) rdcnt[k] = 0;
        drive_data();
        repeat (3) @(negedge clk);
        check(ser === 1'b0, "R1 reset ser", int'(ser), 0, -1);
        check(sof === 1'b0, "R1 reset sof", int'(sof), 0, -1);
        check(stb === 4'h0, "R1 reset strobes", int'(stb), 0, -1);
        rst = 1'b0;
    endtask

    // First frame ignores the pending request; request withdrawn before wrap.
    task automatic t_plain();
        run(400);
        jreq = 4'h0;
        run(FL - 400);
        run(FL);
    endtask

    task automatic t_justify();
        jreq = 4'b0101;
        run(FL);
        jreq = 4'b1010;
        run(FL);
        jreq = 4'b0000;
        run(FL);
    endtask

    task automatic t_starve();
        avail = 4'b1011;
        jreq  = 4'b1000;
        run(FL);
        jreq  = 4'b0000;
        run(FL);
        avail = 4'hF;
    endtask

    task automatic t_midreset();
        jreq = 4'b0110;
        run(150);
        t_reset();
        jreq = 4'b0000;
        run(FL);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_justify();
        t_starve();
        t_midreset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule